// File: doc/BRIEF.md
# Envelope Tracking Signal Generator

This block takes the transmit I/Q sample stream and produces, alongside it, a supply-envelope sample stream for a power amplifier whose supply rail follows the signal envelope. Each accepted sample first passes through a four-tap FIR whose signed Q1.15 coefficients realise a sub-sample delay. The magnitude of the delayed sample is then estimated, and the magnitude is remapped by a polynomial of programmable order, evaluated by Horner's rule and clipped to an unsigned 12-bit envelope code. The envelope results queue in one buffer. The untouched input samples queue in a second buffer.

The two buffers are released independently. Each has its own start tick from the system timing logic, so the whole-sample offset between the envelope and I/Q streams is set by when those ticks arrive. After release, each sampling-clock enable (`sampleEn`, one per output sample at four times the chip rate) moves one sample from each running buffer to its output. Coefficients, polynomial order and coefficient-bank choice are written into shadow registers. They become active only at the next envelope start tick, so a reconfiguration never lands in the middle of a burst.

Top module: `envTrackGen`

## Requirements
- R1: While `rstN` is low and until the first output step, `envOut`, `iqOutI` and `iqOutQ` are 0, both valid outputs are 0, both underrun outputs are 0, both buffers are empty, and all four delay taps are zero.
- R2: For each accepted input (`inValid` high), the delayed sample is y = floor((c0*x0 + c1*x1 + c2*x2 + c3*x3) / 2^15), saturated to the signed 16-bit range. This is computed separately for I and Q. x0 is the newest accepted sample and x3 is the oldest of the last four. c0..c3 are signed 16-bit values at config addresses 0..3, with reset values c0=32767 and c1=c2=c3=0.
- R3: The magnitude of a delayed pair (I', Q') is max(|I'|,|Q'|) + floor(min(|I'|,|Q'|)/2). This is an unsigned value no larger than 49152.
- R4: The envelope code is computed with m equal to the magnitude, N equal to the order, and a0..aN the selected bank. The accumulator starts at aN. Then, for k = N-1 down to 0, acc = floor(acc*m/65536) + ak. The result is clipped to the range 0..4095.
- R5: Bank 0 coefficients a0..a4 sit at addresses 8..12 and bank 1 at addresses 16..20, all signed 16-bit. Bit 0 of address 25 selects the bank. Address 24 sets the order: a written value of 0 becomes 1, and a value above 4 becomes 4. The reset values are order 1, bank 0, bank-0 a1=4095, and all other coefficients 0.
- R6: Writes to addresses 0..25 change only shadow copies. These copies become active on the clock edge where `envTick` is high, and `iqTick` does not load them. The minimum fill at address 26 (7 bits, reset value 1) takes effect at once.
- R7: The I/Q buffer stores the raw input samples, without the delay filter. It is released only by `iqTick`, independently of `envTick`.
- R8: A start tick sets a path running when its buffer holds at least the minimum fill. While it is running, each `sampleEn` pops one sample. The sample appears on that path's output one cycle later with its valid output high for that cycle.
- R9: A start tick that finds fewer samples than the minimum fill sets that path's underrun output. Until that path's next tick, each `sampleEn` then gives valid with data 0 and pops nothing.
- R10: A `sampleEn` on a running path whose buffer is empty gives valid with data 0, sets underrun and stops the path.
- R11: Each buffer holds at most 64 samples. A sample that arrives at a full buffer is discarded.
- R12: Before a path's first start tick, `sampleEn` has no effect on it: valid stays low and the data output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 16 | Signed in-phase input |
| inQ | input | 16 | Signed quadrature input |
| cfgWe | input | 1 | Config write strobe |
| cfgAddr | input | 5 | Config address |
| cfgData | input | 16 | Config write data |
| envTick | input | 1 | Envelope buffer start tick; also activates shadow config |
| iqTick | input | 1 | I/Q buffer start tick |
| sampleEn | input | 1 | Sampling-clock enable, one output sample per pulse |
| envOut | output | 12 | Envelope code |
| envValid | output | 1 | Envelope output valid |
| envUnderrun | output | 1 | Envelope path underrun |
| iqOutI | output | 16 | Released in-phase sample |
| iqOutQ | output | 16 | Released quadrature sample |
| iqValid | output | 1 | I/Q output valid |
| iqUnderrun | output | 1 | I/Q path underrun |

## Verification
A wrong tap, a wrong magnitude or a wrong polynomial step appears as a wrong `envOut` code on the first step after release. The I/Q path stays correct while this happens, which separates a datapath fault from a release fault. A buffer-count fault shows as an early or missing underrun, or as a zero in place of data, on the step where the count crosses empty or the minimum fill. A fault in the shadow-to-active transfer shows only on samples accepted after an envelope tick. For that reason, samples are placed on both sides of each tick, and the configuration is applied on an envelope tick only.

// File: rtl/envTrackPkg.sv
package envTrackPkg;
  localparam int SAMPLE_W  = 16;
  localparam int ENV_W     = 12;
  localparam int NUM_TAPS  = 4;
  localparam int MAX_ORDER = 4;
  localparam int NUM_BANKS = 2;
  localparam int ORDER_W   = $clog2(MAX_ORDER + 1);
  localparam int PATH_ENV  = 0;
  localparam int PATH_IQ   = 1;

  localparam logic [4:0] ADDR_ORDER = 5'd24;
  localparam logic [4:0] ADDR_BANK  = 5'd25;
  localparam logic [4:0] ADDR_FILL  = 5'd26;

  typedef struct packed {
    logic [NUM_TAPS-1:0][SAMPLE_W-1:0]               tap;
    logic [NUM_BANKS-1:0][MAX_ORDER:0][SAMPLE_W-1:0] coef;
    logic [ORDER_W-1:0]                              order;
    logic                                            bankSel;
  } shapeCfgT;

  typedef struct packed {
    logic [1:0] emit;
    logic [1:0] pop;
  } strobeT;

  function automatic shapeCfgT resetCfg();
    shapeCfgT c;
    c = '0;
    c.tap[0]     = 16'h7FFF;
    c.coef[0][1] = 16'd4095;
    c.order      = ORDER_W'(1);
    return c;
  endfunction

  function automatic logic [ORDER_W-1:0] clampOrder(input logic [SAMPLE_W-1:0] d);
    if (d == '0) return ORDER_W'(1);
    else if (d > SAMPLE_W'(MAX_ORDER)) return ORDER_W'(MAX_ORDER);
    else return d[ORDER_W-1:0];
  endfunction
endpackage

// File: rtl/sampleFifo.sv
module sampleFifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPush   = push && (count != CW'(DEPTH));
  assign doPop    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/envCtrl.sv
module envCtrl import envTrackPkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [4:0]            cfgAddr,
  input  logic [SAMPLE_W-1:0]   cfgData,
  input  logic                  envTick,
  input  logic                  iqTick,
  input  logic                  sampleEn,
  input  logic [1:0][CW-1:0]    fillCount,
  output shapeCfgT              activeCfg,
  output strobeT                strobe,
  output logic [1:0]            underrun
);
  shapeCfgT      shadowCfg;
  logic [CW-1:0] minFill;
  logic [1:0]    ticks, emitV, popV;

  assign ticks  = {iqTick, envTick};
  assign strobe = '{emit: emitV, pop: popV};

  // shadow registers and the immediate minimum-fill register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowCfg <= resetCfg();
      minFill   <= CW'(1);
    end else if (cfgWe) begin
      if (cfgAddr[4:2] == 3'b000)
        shadowCfg.tap[cfgAddr[1:0]] <= cfgData;
      else if ((cfgAddr[4:3] == 2'b01 || cfgAddr[4:3] == 2'b10) && cfgAddr[2:0] <= 3'd4)
        shadowCfg.coef[cfgAddr[4]][cfgAddr[2:0]] <= cfgData;
      else if (cfgAddr == ADDR_ORDER)
        shadowCfg.order <= clampOrder(cfgData);
      else if (cfgAddr == ADDR_BANK)
        shadowCfg.bankSel <= cfgData[0];
      else if (cfgAddr == ADDR_FILL)
        minFill <= cfgData[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        activeCfg <= resetCfg();
    else if (envTick) activeCfg <= shadowCfg;
  end

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic started, running, underrunR, lowFill, empty;

    assign lowFill     = fillCount[p] < minFill;
    assign empty       = fillCount[p] == '0;
    assign emitV[p]    = sampleEn && started && !ticks[p];
    assign popV[p]     = emitV[p] && running && !empty;
    assign underrun[p] = underrunR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        started   <= 1'b0;
        running   <= 1'b0;
        underrunR <= 1'b0;
      end else if (ticks[p]) begin
        started   <= 1'b1;
        running   <= !lowFill;
        underrunR <= lowFill;
      end else if (emitV[p] && running && empty) begin
        running   <= 1'b0;
        underrunR <= 1'b1;
      end
    end
  end

  assert_order_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    activeCfg.order >= ORDER_W'(1) && activeCfg.order <= ORDER_W'(MAX_ORDER));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !envTick |=> $stable(activeCfg));
endmodule

// File: rtl/envDatapath.sv
module envDatapath import envTrackPkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  shapeCfgT                   cfg,
  input  strobeT                     strobe,
  output logic [1:0][CW-1:0]         fillCount,
  output logic [ENV_W-1:0]           envOut,
  output logic                       envValid,
  output logic [SAMPLE_W-1:0]        iqOutI,
  output logic [SAMPLE_W-1:0]        iqOutQ,
  output logic                       iqValid
);
  localparam int ACC_W  = 2 * SAMPLE_W + $clog2(NUM_TAPS);
  localparam int HACC_W = 2 * SAMPLE_W;
  localparam int PROD_W = HACC_W + SAMPLE_W + 1;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -ACC_W'(1 << (SAMPLE_W - 1));
  localparam int ENV_MAX = (1 << ENV_W) - 1;

  function automatic logic signed [SAMPLE_W-1:0] satSample(input logic signed [ACC_W-1:0] v);
    if (v > POS_LIM) return SAMPLE_W'(POS_LIM);
    else if (v < NEG_LIM) return SAMPLE_W'(NEG_LIM);
    else return v[SAMPLE_W-1:0];
  endfunction

  function automatic logic signed [HACC_W-1:0] sext(input logic [SAMPLE_W-1:0] v);
    return {{(HACC_W - SAMPLE_W){v[SAMPLE_W-1]}}, v};
  endfunction

  // stage 1: tap delay line
  logic signed [SAMPLE_W-1:0] tapI [NUM_TAPS];
  logic signed [SAMPLE_W-1:0] tapQ [NUM_TAPS];
  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        tapI[k] <= '0;
        tapQ[k] <= '0;
      end
    end else if (inValid) begin
      tapI[0] <= inI;
      tapQ[0] <= inQ;
      for (int k = 1; k < NUM_TAPS; k++) begin
        tapI[k] <= tapI[k-1];
        tapQ[k] <= tapQ[k-1];
      end
    end
  end

  // stage 2: fractional-delay FIR
  logic signed [ACC_W-1:0]      sumI, sumQ;
  logic signed [2*SAMPLE_W-1:0] prodI, prodQ;
  logic signed [SAMPLE_W-1:0]   dlyI, dlyQ;

  always_comb begin
    sumI = '0;
    sumQ = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      prodI = tapI[k] * $signed(cfg.tap[k]);
      prodQ = tapQ[k] * $signed(cfg.tap[k]);
      sumI  = sumI + ACC_W'(prodI);
      sumQ  = sumQ + ACC_W'(prodQ);
    end
  end

  // stage 3: magnitude estimate
  logic signed [SAMPLE_W:0] extI, extQ, absI, absQ, bigV, smallV, magNext;
  logic [SAMPLE_W-1:0]      magR;

  always_comb begin
    extI    = {dlyI[SAMPLE_W-1], dlyI};
    extQ    = {dlyQ[SAMPLE_W-1], dlyQ};
    absI    = extI[SAMPLE_W] ? -extI : extI;
    absQ    = extQ[SAMPLE_W] ? -extQ : extQ;
    bigV    = (absI > absQ) ? absI : absQ;
    smallV  = (absI > absQ) ? absQ : absI;
    magNext = bigV + (smallV >>> 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      dlyI <= '0; dlyQ <= '0; magR <= '0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
      if (v1) begin
        dlyI <= satSample(sumI >>> (SAMPLE_W - 1));
        dlyQ <= satSample(sumQ >>> (SAMPLE_W - 1));
      end
      if (v2) magR <= magNext[SAMPLE_W-1:0];
    end
  end

  // stage 4: polynomial shaping by Horner's rule
  logic signed [HACC_W-1:0] hAcc;
  logic signed [PROD_W-1:0] hProd;
  logic signed [SAMPLE_W:0] magS;
  logic [ENV_W-1:0]         shaped;

  always_comb begin
    magS  = {1'b0, magR};
    hAcc  = sext(cfg.coef[cfg.bankSel][cfg.order]);
    hProd = '0;
    for (int k = MAX_ORDER - 1; k >= 0; k--) begin
      if (k < int'(cfg.order)) begin
        hProd = hAcc * magS;
        hAcc  = hProd[HACC_W+SAMPLE_W-1:SAMPLE_W] + sext(cfg.coef[cfg.bankSel][3'(k)]);
      end
    end
    if (hAcc[HACC_W-1])                   shaped = '0;
    else if (hAcc > HACC_W'(ENV_MAX))     shaped = ENV_W'(ENV_MAX);
    else                                  shaped = hAcc[ENV_W-1:0];
  end

  // buffers
  logic [ENV_W-1:0]      envHead;
  logic [2*SAMPLE_W-1:0] iqHead;

  sampleFifo #(.WIDTH(ENV_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_envFifo (
    .clk(clk), .rstN(rstN), .push(v3), .pushData(shaped),
    .pop(strobe.pop[PATH_ENV]), .headData(envHead), .count(fillCount[PATH_ENV]));

  sampleFifo #(.WIDTH(2*SAMPLE_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_iqFifo (
    .clk(clk), .rstN(rstN), .push(inValid), .pushData({inI, inQ}),
    .pop(strobe.pop[PATH_IQ]), .headData(iqHead), .count(fillCount[PATH_IQ]));

  // output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      envOut <= '0; envValid <= 1'b0;
      iqOutI <= '0; iqOutQ <= '0; iqValid <= 1'b0;
    end else begin
      envValid <= strobe.emit[PATH_ENV];
      iqValid  <= strobe.emit[PATH_IQ];
      if (strobe.emit[PATH_ENV])
        envOut <= strobe.pop[PATH_ENV] ? envHead : '0;
      if (strobe.emit[PATH_IQ])
        {iqOutI, iqOutQ} <= strobe.pop[PATH_IQ] ? iqHead : '0;
    end
  end

  assert_mag_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    v3 |-> (magR <= SAMPLE_W'(49152)));
endmodule

// File: rtl/envTrackGen.sv
module envTrackGen import envTrackPkg::*; #(
  parameter int FIFO_DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  logic                       cfgWe,
  input  logic [4:0]                 cfgAddr,
  input  logic [SAMPLE_W-1:0]        cfgData,
  input  logic                       envTick,
  input  logic                       iqTick,
  input  logic                       sampleEn,
  output logic [ENV_W-1:0]           envOut,
  output logic                       envValid,
  output logic                       envUnderrun,
  output logic [SAMPLE_W-1:0]        iqOutI,
  output logic [SAMPLE_W-1:0]        iqOutQ,
  output logic                       iqValid,
  output logic                       iqUnderrun
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  shapeCfgT          activeCfg;
  strobeT            strobe;
  logic [1:0]        underrun;
  logic [1:0][CW-1:0] fillCount;

  assign envUnderrun = underrun[PATH_ENV];
  assign iqUnderrun  = underrun[PATH_IQ];

  envCtrl #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .envTick(envTick), .iqTick(iqTick), .sampleEn(sampleEn), .fillCount(fillCount),
    .activeCfg(activeCfg), .strobe(strobe), .underrun(underrun));

  envDatapath #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .cfg(activeCfg), .strobe(strobe), .fillCount(fillCount),
    .envOut(envOut), .envValid(envValid), .iqOutI(iqOutI), .iqOutQ(iqOutQ),
    .iqValid(iqValid));

  assert_underrun_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (envValid && envUnderrun) |-> (envOut == '0));

  assert_valid_after_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (envValid || iqValid) |-> $past(sampleEn));
endmodule

// File: tb/envTrackGen_tb.sv
module envTrackGen_tb;
  localparam int DEPTH = 64;
  localparam logic [31:0] VEC [8] = '{
    {16'sd1000,   16'sd0},     {16'sd0,     -16'sd2000},
    {-16'sd32768, -16'sd32768}, {16'sd12000, 16'sd9000},
    {-16'sd7000,  16'sd15000}, {16'sd32767, -16'sd1},
    {16'sd300,    16'sd300},   {-16'sd1,    16'sd1}};

  logic clk = 0, rstN = 0, inValid = 0, cfgWe = 0, envTick = 0, iqTick = 0, sampleEn = 0;
  logic signed [15:0] inI = 0, inQ = 0;
  logic [4:0] cfgAddr = 0;
  logic [15:0] cfgData = 0;
  logic [11:0] envOut;
  logic envValid, envUnderrun, iqValid, iqUnderrun;
  logic [15:0] iqOutI, iqOutQ;

  always #5 clk = ~clk;

  envTrackGen u_dut (.*);

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // bench-side model state
  longint hI[4], hQ[4];
  longint sTap[4], aTap[4];
  longint sCoef[2][5], aCoef[2][5];
  int sOrd, aOrd, sSel, aSel, minFill;
  int envQ[$];
  logic [31:0] iqQ[$];
  bit eStart, eRun, eUnd, iStart, iRun, iUnd;
  int lastEnv;
  logic [31:0] lastIq;

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint satv(longint v, longint lo, longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int modelEnv();
    longint sI = 0, sQ = 0, aI, aQ, big, sml, m, acc;
    for (int k = 0; k < 4; k++) begin
      sI += hI[k] * aTap[k];
      sQ += hQ[k] * aTap[k];
    end
    sI = satv(sI >>> 15, -32768, 32767);
    sQ = satv(sQ >>> 15, -32768, 32767);
    aI = (sI < 0) ? -sI : sI;
    aQ = (sQ < 0) ? -sQ : sQ;
    big = (aI > aQ) ? aI : aQ;
    sml = (aI > aQ) ? aQ : aI;
    m = big + (sml >>> 1);
    acc = aCoef[aSel][aOrd];
    for (int k = aOrd - 1; k >= 0; k--) acc = ((acc * m) >>> 16) + aCoef[aSel][k];
    return int'(satv(acc, 0, 4095));
  endfunction

  task automatic resetModel();
    for (int k = 0; k < 4; k++) begin hI[k] = 0; hQ[k] = 0; sTap[k] = 0; end
    sTap[0] = 32767;
    for (int b = 0; b < 2; b++) for (int k = 0; k < 5; k++) sCoef[b][k] = 0;
    sCoef[0][1] = 4095;
    sOrd = 1; sSel = 0; minFill = 1;
    aTap = sTap; aCoef = sCoef; aOrd = sOrd; aSel = sSel;
    envQ.delete(); iqQ.delete();
    {eStart, eRun, eUnd, iStart, iRun, iUnd} = '0;
    lastEnv = 0; lastIq = 0;
  endtask

  task automatic pushSample(int i, int q);
    @(negedge clk);
    inValid = 1; inI = 16'(i); inQ = 16'(q);
    for (int k = 3; k > 0; k--) begin hI[k] = hI[k-1]; hQ[k] = hQ[k-1]; end
    hI[0] = i; hQ[0] = q;
    if (envQ.size() < DEPTH) envQ.push_back(modelEnv());
    if (iqQ.size() < DEPTH) iqQ.push_back({16'(i), 16'(q)});
    @(negedge clk);
    inValid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic writeCfg(int a, int d);
    @(negedge clk);
    cfgWe = 1; cfgAddr = 5'(a); cfgData = 16'(d);
    if (a < 4) sTap[a] = d;
    else if (a >= 8 && a <= 12) sCoef[0][a-8] = d;
    else if (a >= 16 && a <= 20) sCoef[1][a-16] = d;
    else if (a == 24) sOrd = (d == 0) ? 1 : ((d > 4) ? 4 : d);
    else if (a == 25) sSel = d & 1;
    else if (a == 26) minFill = d & 127;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic tick(bit env, bit iq);
    @(negedge clk);
    envTick = env; iqTick = iq;
    if (env) begin
      eStart = 1; eRun = (envQ.size() >= minFill); eUnd = !eRun;
      aTap = sTap; aCoef = sCoef; aOrd = sOrd; aSel = sSel;
    end
    if (iq) begin
      iStart = 1; iRun = (iqQ.size() >= minFill); iUnd = !iRun;
    end
    @(negedge clk);
    envTick = 0; iqTick = 0;
  endtask

  task automatic step(string tag);
    bit ev = 0, iv = 0;
    @(negedge clk);
    sampleEn = 1;
    if (eStart) begin
      ev = 1;
      if (eRun && envQ.size() > 0) lastEnv = envQ.pop_front();
      else begin lastEnv = 0; if (eRun) begin eRun = 0; eUnd = 1; end end
    end
    if (iStart) begin
      iv = 1;
      if (iRun && iqQ.size() > 0) lastIq = iqQ.pop_front();
      else begin lastIq = 0; if (iRun) begin iRun = 0; iUnd = 1; end end
    end
    @(negedge clk);
    sampleEn = 0;
    check({tag, " envValid"}, envValid, ev);
    check({tag, " envOut"}, envOut, lastEnv);
    check({tag, " envUnderrun"}, envUnderrun, eUnd);
    check({tag, " iqValid"}, iqValid, iv);
    check({tag, " iqOut"}, {iqOutI, iqOutQ}, lastIq);
    check({tag, " iqUnderrun"}, iqUnderrun, iUnd);
  endtask

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 envOut", envOut, 0);
    check("R1 envValid", envValid, 0);
    check("R1 envUnderrun", envUnderrun, 0);
    check("R1 iqValid", iqValid, 0);
    check("R1 iqOut", {iqOutI, iqOutQ}, 0);
    check("R1 iqUnderrun", iqUnderrun, 0);
    rstN = 1;
    // R12: steps before any start tick do nothing
    step("R12 pre-tick");

    // R2 R3 R4 R7 R8: table of input vectors through the default configuration
    for (int n = 0; n < 8; n++) pushSample(int'($signed(VEC[n][31:16])), int'($signed(VEC[n][15:0])));
    tick(1, 1);
    for (int n = 0; n < 8; n++) step("R8 table R2 R3 R4 R7");
    // R10: running buffers drained
    step("R10 empty");
    // R9: tick with empty buffer
    tick(1, 0);
    step("R9 env underrun");

    // R6: shadow config activates only on the envelope tick
    writeCfg(8, 100); writeCfg(9, 2000); writeCfg(10, 3000); writeCfg(24, 2);
    pushSample(9000, -4000);
    tick(1, 1);
    pushSample(9000, -4000);
    pushSample(-20000, 5000);
    step("R6 old cfg"); step("R6 new cfg"); step("R6 new cfg 2");

    // R6: iqTick alone does not load config
    writeCfg(24, 1); writeCfg(8, 0); writeCfg(9, 4095);
    tick(0, 1);
    pushSample(16000, 16000);
    tick(0, 1);
    step("R6 iq tick no load");
    tick(1, 0);
    pushSample(16000, 16000);
    tick(1, 1);
    step("R6 env tick load");

    // R5: bank select and order clamping
    writeCfg(16, 4095); writeCfg(17, -4095); writeCfg(25, 1); writeCfg(24, 0);
    tick(1, 1);
    pushSample(20000, -3000); pushSample(-500, 700);
    tick(1, 1);
    step("R5 bank1"); step("R5 bank1 order0");
    writeCfg(25, 0); writeCfg(8, 10); writeCfg(9, 1000); writeCfg(10, -500);
    writeCfg(11, 2000); writeCfg(12, 1500); writeCfg(24, 7);
    tick(1, 1);
    pushSample(30000, 12000); pushSample(-8000, -8000);
    tick(1, 1);
    step("R5 order4"); step("R5 order4 b");

    // R4: output clipping at both ends
    writeCfg(24, 1); writeCfg(8, 5000); writeCfg(9, 0);
    tick(1, 1);
    pushSample(100, 100);
    writeCfg(8, -100);
    tick(1, 1);
    pushSample(100, 100);
    step("R4 clip high"); step("R4 clip low");

    // R2: fractional delay with all taps active
    writeCfg(8, 0); writeCfg(9, 4095);
    writeCfg(0, 16384); writeCfg(1, 16384); writeCfg(2, -8192); writeCfg(3, 8192);
    tick(1, 1);
    pushSample(20000, -10000); pushSample(-15000, 25000);
    pushSample(32767, 32767); pushSample(-32768, 4000);
    tick(1, 1);
    for (int n = 0; n < 4; n++) step("R2 taps");

    // R9: minimum fill not reached
    writeCfg(26, 3);
    pushSample(1234, 4321); pushSample(-2222, 1111);
    tick(1, 1);
    step("R9 below fill");
    pushSample(5555, -6666);
    tick(1, 1);
    for (int n = 0; n < 3; n++) step("R9 fill reached");

    // R7: iq path released on its own tick
    writeCfg(26, 1);
    pushSample(700, -800);
    tick(0, 1);
    step("R7 iq only");
    tick(1, 0);
    step("R7 env later");

    // R11: overflow discards
    for (int n = 0; n < DEPTH + 2; n++) pushSample(n * 300 - 9000, 4000 - n * 100);
    tick(1, 1);
    for (int n = 0; n < DEPTH; n++) step("R11 full buffer");
    step("R11 drained R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule